// File: doc/BRIEF.md
# Adaptive Cut-Through Transmit FIFO Controller

This block sits between a host-side packet writer and a link transmitter. The writer pushes 32-bit words, and the last word of each packet carries an end marker. The block buffers them in a 2048-byte FIFO and decides when the head packet may begin to leave. In cut-through mode a packet starts once the buffered word count reaches a programmable threshold, or once its end marker is stored, whichever comes first. In store-and-forward mode it waits for the end marker.

If the FIFO runs dry while a cut-through packet is in flight, the block raises a one-cycle underrun pulse and ends the transfer without an end marker, so the receiver sees an errored packet. It then discards the rest of that packet as the writer delivers it. The next packet is treated as the host's resend and always goes out store-and-forward. Once that packet completes, the programmed threshold applies again.

A global enhancement enable and a retry-limit input can both force store-and-forward. In store-and-forward mode, a packet that fills the whole FIFO without an end marker is reported as oversize and dropped.

Top module: `at_cutthru_fifo`

## Requirements
- R1: After reset, tx_valid, underrun and oversize are 0, wr_ready is 1, and the threshold register holds code 01.
- R2: The threshold codes map to buffered-word levels as follows: code 01 is 432 words (1728 bytes), code 10 is 256 words and code 11 is 128 words. In cut-through mode the head packet starts within 4 cycles of the buffered count reaching that level.
- R3: A packet whose end marker is already stored starts even if the buffered count is below the threshold.
- R4: Threshold code 00 selects store-and-forward: no word of a packet is sent before its end marker has been written.
- R5: With cfg_enh_en at 0, every packet is sent store-and-forward whatever the threshold code.
- R6: With cfg_retry_lim equal to 0, every packet is sent store-and-forward whatever the threshold code.
- R7: When the FIFO is empty while a started packet's end marker is still unsent and the link can take a word, underrun pulses high for exactly one cycle. tx_valid drops without a word marked last being sent.
- R8: After an underrun, the remaining words of that packet, up to and including its end marker, are discarded and never appear on tx_data.
- R9: The packet written after an underrun is sent store-and-forward. After it completes, the next packet uses the programmed threshold again.
- R10: wr_ready is low whenever 512 words are buffered.
- R11: In store-and-forward mode, a packet that fills all 512 words without an end marker pulses oversize for one cycle and is dropped entirely. The packet after it is delivered intact.
- R12: Words leave in write order. tx_data and tx_last hold steady while tx_valid is high and tx_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Writer offers a word |
| wr_data | input | 32 | Word from the writer |
| wr_last | input | 1 | Word is the end of its packet |
| wr_ready | output | 1 | FIFO can accept a word this cycle |
| tx_valid | output | 1 | Word presented to the link |
| tx_data | output | 32 | Word to the link |
| tx_last | output | 1 | Presented word ends the packet |
| tx_ready | input | 1 | Link takes the presented word |
| underrun | output | 1 | One-cycle pulse on FIFO underrun |
| oversize | output | 1 | One-cycle pulse when a store-and-forward packet overflows |
| cfg_th_we | input | 1 | Load cfg_th_val into the threshold register |
| cfg_th_val | input | 2 | Threshold code |
| cfg_enh_en | input | 1 | Global enable for the threshold feature |
| cfg_retry_lim | input | 4 | Retry limit; zero forces store-and-forward |

## Verification
Packets are written at one word per cycle under each threshold code. The writer's count at the first transmitted word separates threshold starts (R2), end-marker starts (R3) and forced store-and-forward (R4 to R6). A packet whose writer pauses for a long stretch in mid-packet drives the FIFO dry. That pattern shows the underrun pulse, the discard of the tail, the store-and-forward resend and the return to cut-through. A 600-word store-and-forward packet exercises the full stall and the oversize drop. A link that stalls every third cycle checks word order and hold behaviour.

// File: rtl/atc_pkg.sv
package atc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_DROP = 2'd2
  } atc_state_e;
endpackage

// File: rtl/atc_store.sv
// Word storage: data array with registered read (block-RAM friendly),
// end-marker bits with an extra combinational peek at the head slot.
module atc_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          wlast,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rlast,
  output logic          head_last
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] endbits;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (we) endbits[waddr] <= wlast;
    if (re) rlast <= endbits[raddr];
  end

  assign head_last = endbits[raddr];
endmodule

// File: rtl/atc_level.sv
// Pointers, fill level and count of stored end markers.
module atc_level #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          push_last,
  input  logic          pop,
  input  logic          pop_last,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] level,
  output logic          eop_any,
  output logic          full
);
  logic [CW-1:0] level_n;
  logic [CW-1:0] eops, eops_n;

  always_comb begin
    level_n = level;
    if (push) level_n = level_n + CW'(1);
    if (pop)  level_n = level_n - CW'(1);
    eops_n = eops;
    if (push && push_last) eops_n = eops_n + CW'(1);
    if (pop && pop_last)   eops_n = eops_n - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      eops   <= '0;
      full   <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      level <= level_n;
      eops  <= eops_n;
      full  <= (level_n == CW'(DEPTH));
    end
  end

  assign eop_any = (eops != '0);
endmodule

// File: rtl/atc_seq.sv
// Start/send/discard sequencer with underrun and oversize detection.
module atc_seq
  import atc_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CW    = 10,
  parameter int TH1_W = 432,
  parameter int TH2_W = 256,
  parameter int TH3_W = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] level,
  input  logic          eop_any,
  input  logic          head_last,
  input  logic          tx_last,
  input  logic          tx_ready,
  input  logic [1:0]    th_code,
  input  logic          enh_en,
  input  logic          retry_zero,
  output logic          pop,
  output logic          tx_valid,
  output logic          underrun,
  output logic          oversize,
  output atc_state_e    st,
  output logic          saf_q
);
  logic          retry_pend, last_taken;
  logic          saf_now, th_hit, start, ovs, wants, pop_send, urun, done;
  logic [CW-1:0] th_w;

  always_comb begin
    case (th_code)
      2'b01:   th_w = CW'(TH1_W);
      2'b10:   th_w = CW'(TH2_W);
      2'b11:   th_w = CW'(TH3_W);
      default: th_w = CW'(DEPTH);
    endcase
    saf_now  = !enh_en || retry_zero || (th_code == 2'b00) || retry_pend;
    th_hit   = (level >= th_w);
    start    = (st == ST_IDLE) && (level != '0) && (eop_any || (!saf_now && th_hit));
    ovs      = (st == ST_IDLE) && saf_now && !eop_any && (level == CW'(DEPTH));
    wants    = !tx_valid || tx_ready;
    pop_send = (st == ST_SEND) && !last_taken && (level != '0) && wants;
    urun     = (st == ST_SEND) && !last_taken && (level == '0) && wants;
    done     = (st == ST_SEND) && tx_valid && tx_ready && tx_last;
    pop      = pop_send || ((st == ST_DROP) && (level != '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      saf_q      <= 1'b0;
      retry_pend <= 1'b0;
      last_taken <= 1'b0;
      tx_valid   <= 1'b0;
      underrun   <= 1'b0;
      oversize   <= 1'b0;
    end else begin
      underrun <= urun;
      oversize <= ovs;
      if (pop_send)      tx_valid <= 1'b1;
      else if (tx_ready) tx_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st         <= ST_SEND;
            saf_q      <= saf_now;
            last_taken <= 1'b0;
          end else if (ovs) begin
            st <= ST_DROP;
          end
        end
        ST_SEND: begin
          if (pop_send && head_last) last_taken <= 1'b1;
          if (urun) begin
            st         <= ST_DROP;
            retry_pend <= 1'b1;
          end else if (done) begin
            st         <= ST_IDLE;
            retry_pend <= 1'b0;
          end
        end
        ST_DROP: begin
          if (pop && head_last) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/at_cutthru_fifo.sv
module at_cutthru_fifo
  import atc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_BYTES = 2048,
  parameter int TH1_BYTES  = 1728,
  parameter int TH2_BYTES  = 1024,
  parameter int TH3_BYTES  = 512,
  parameter int RETRY_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_last,
  output logic               wr_ready,
  output logic               tx_valid,
  output logic [DATA_W-1:0]  tx_data,
  output logic               tx_last,
  input  logic               tx_ready,
  output logic               underrun,
  output logic               oversize,
  input  logic               cfg_th_we,
  input  logic [1:0]         cfg_th_val,
  input  logic               cfg_enh_en,
  input  logic [RETRY_W-1:0] cfg_retry_lim
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int DEPTH      = FIFO_BYTES / WORD_BYTES;
  localparam int AW         = $clog2(DEPTH);
  localparam int CW         = AW + 1;
  localparam int TH1_W      = TH1_BYTES / WORD_BYTES;
  localparam int TH2_W      = TH2_BYTES / WORD_BYTES;
  localparam int TH3_W      = TH3_BYTES / WORD_BYTES;

  logic [1:0]    th_code;
  logic          push, pop, full, eop_any, head_last, saf_q;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;
  atc_state_e    st;

  always_ff @(posedge clk) begin
    if (rst)            th_code <= 2'b01;
    else if (cfg_th_we) th_code <= cfg_th_val;
  end

  assign wr_ready = !full;
  assign push     = wr_valid && !full;

  atc_level #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_level (
    .clk(clk), .rst(rst), .push(push), .push_last(wr_last), .pop(pop),
    .pop_last(head_last), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level),
    .eop_any(eop_any), .full(full)
  );

  atc_store #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(push), .waddr(wr_ptr), .wdata(wr_data), .wlast(wr_last),
    .re(pop), .raddr(rd_ptr), .rdata(tx_data), .rlast(tx_last),
    .head_last(head_last)
  );

  atc_seq #(.DEPTH(DEPTH), .CW(CW), .TH1_W(TH1_W), .TH2_W(TH2_W), .TH3_W(TH3_W)) u_seq (
    .clk(clk), .rst(rst), .level(level), .eop_any(eop_any), .head_last(head_last),
    .tx_last(tx_last), .tx_ready(tx_ready), .th_code(th_code), .enh_en(cfg_enh_en),
    .retry_zero(cfg_retry_lim == '0), .pop(pop), .tx_valid(tx_valid),
    .underrun(underrun), .oversize(oversize), .st(st), .saf_q(saf_q)
  );
endmodule

// File: rtl/atc_checker.sv
module atc_checker
  import atc_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CW    = 10,
  parameter int DW    = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_ready,
  input logic [CW-1:0] level,
  input logic          eop_any,
  input atc_state_e    st,
  input logic          saf_q,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          tx_last,
  input logic          underrun,
  input logic          oversize
);
  p_stall_full_r10: assert property (@(posedge clk) disable iff (rst)
    (level == CW'(DEPTH)) |-> !wr_ready);

  p_urun_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun);

  p_urun_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    underrun |-> !tx_valid);

  p_drop_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DROP) |-> !tx_valid);

  p_saf_wait_r4: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_SEND) && ($past(st) == ST_IDLE) && saf_q) |-> $past(eop_any));

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_ovs_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    oversize |=> !oversize);

  p_ovs_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(underrun && oversize));
endmodule

bind at_cutthru_fifo atc_checker #(.DEPTH(DEPTH), .CW(CW), .DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_ready(wr_ready), .level(level), .eop_any(eop_any),
  .st(st), .saf_q(saf_q), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .underrun(underrun), .oversize(oversize)
);

// File: tb/sim_at_cutthru_fifo.sv
module sim_at_cutthru_fifo;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, wr_valid, wr_last, wr_ready, tx_valid, tx_last, tx_ready;
  logic [31:0] wr_data, tx_data;
  logic        underrun, oversize, cfg_th_we, cfg_enh_en;
  logic [1:0]  cfg_th_val;
  logic [3:0]  cfg_retry_lim;

  at_cutthru_fifo u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
    .wr_ready(wr_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .underrun(underrun), .oversize(oversize),
    .cfg_th_we(cfg_th_we), .cfg_th_val(cfg_th_val), .cfg_enh_en(cfg_enh_en),
    .cfg_retry_lim(cfg_retry_lim)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [32:0] expq[$];
  int  wr_count, st_wr, n_urun, n_ovs, rx_n, rdy_mode;
  logic lastw, st_lw;
  bit  started, in_pkt, saw_full, finished;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1 tx_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  // monitor / scoreboard
  always @(negedge clk) if (!rst) begin
    if (!wr_ready) saw_full = 1;
    if (underrun) begin n_urun++; in_pkt = 0; end
    if (oversize) n_ovs++;
    if (tx_valid && !in_pkt) begin
      in_pkt = 1;
      if (!started) begin started = 1; st_wr = wr_count; st_lw = lastw; end
    end
    if (tx_valid && tx_ready) begin
      rx_n++;
      if (expq.size() == 0) begin
        total++; bad++;
        $display("FAIL R8 R11 R12: unexpected word actual=%0h expected=none", tx_data);
      end else begin
        logic [32:0] e;
        e = expq.pop_front();
        chk({tx_data, tx_last} == e, "R12 word", int'(tx_data), int'(e[32:1]));
      end
      if (tx_last) in_pkt = 0;
    end
  end

  task automatic put_word(input logic [31:0] d, input logic l);
    bit ok = 0;
    while (!ok) begin
      wr_valid = 1; wr_data = d; wr_last = l;
      @(negedge clk); ok = wr_ready;
      @(posedge clk); #1;
    end
    wr_count++;
    if (l) lastw = 1;
  endtask

  task automatic send_pkt(input int id, input int len, input int pause_at,
                          input int pause_len, input int exp_n);
    started = 0; wr_count = 0; lastw = 0;
    for (int i = 0; i < exp_n; i++)
      expq.push_back({(32'(id) << 24) | 32'(i), i == len - 1});
    @(posedge clk); #1;
    for (int i = 0; i < len; i++) begin
      if (i == pause_at && pause_len > 0) begin
        wr_valid = 0;
        repeat (pause_len) @(posedge clk);
        #1;
      end
      put_word((32'(id) << 24) | 32'(i), i == len - 1);
    end
    wr_valid = 0; wr_last = 0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(posedge clk);
    repeat (30) @(posedge clk);
  endtask

  task automatic set_th(input logic [1:0] v);
    @(posedge clk); #1 cfg_th_we = 1; cfg_th_val = v;
    @(posedge clk); #1 cfg_th_we = 0;
  endtask

  task automatic chk_cut(input string req, input int th);
    chk(started && st_lw == 1'b0, {req, " start before end marker"}, int'(st_lw), 0);
    chk(st_wr >= th && st_wr <= th + 4, {req, " start level"}, st_wr, th);
  endtask

  task automatic chk_saf(input string req);
    chk(started && st_lw == 1'b1, {req, " waits for end marker"}, int'(st_lw), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    int rx0, u0c;
    rst = 1; wr_valid = 0; wr_data = '0; wr_last = 0; tx_ready = 1; rdy_mode = 0;
    cfg_th_we = 0; cfg_th_val = 2'b00; cfg_enh_en = 1; cfg_retry_lim = 4'd3;
    n_urun = 0; n_ovs = 0; rx_n = 0; saw_full = 0; in_pkt = 0; started = 0;
    repeat (5) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!tx_valid, "R1 tx_valid", int'(tx_valid), 0);
    chk(wr_ready, "R1 wr_ready", int'(wr_ready), 1);
    chk(!underrun && !oversize, "R1 pulses", int'(underrun | oversize), 0);

    // R1 default code 01 -> 432 words
    send_pkt(1, 500, -1, 0, 500); drain(); chk_cut("R1 R2 default", 432);
    set_th(2'b11); send_pkt(2, 300, -1, 0, 300); drain(); chk_cut("R2 code11", 128);
    set_th(2'b10); send_pkt(3, 300, -1, 0, 300); drain(); chk_cut("R2 code10", 256);
    set_th(2'b11); send_pkt(4, 10, -1, 0, 10); drain(); chk_saf("R3 short packet");
    set_th(2'b00); send_pkt(5, 300, -1, 0, 300); drain(); chk_saf("R4 code00");
    set_th(2'b11); cfg_enh_en = 0;
    send_pkt(6, 300, -1, 0, 300); drain(); chk_saf("R5 enh off");
    cfg_enh_en = 1; cfg_retry_lim = 0;
    send_pkt(7, 300, -1, 0, 300); drain(); chk_saf("R6 retry zero");
    cfg_retry_lim = 4'd3;

    // underrun: 200 words, long pause, tail of 100
    rx0 = rx_n; u0c = n_urun;
    send_pkt(8, 300, 200, 300, 200); drain();
    chk(n_urun - u0c == 1, "R7 underrun pulses", n_urun - u0c, 1);
    chk(rx_n - rx0 == 200, "R8 words sent before discard", rx_n - rx0, 200);
    chk(!tx_valid, "R7 link idle after underrun", int'(tx_valid), 0);
    send_pkt(8, 300, -1, 0, 300); drain(); chk_saf("R9 resend");
    send_pkt(9, 300, -1, 0, 300); drain(); chk_cut("R9 back to threshold", 128);
    chk(n_urun - u0c == 1, "R9 no new underrun", n_urun - u0c, 1);

    // link backpressure
    rdy_mode = 1; rx0 = rx_n;
    set_th(2'b00); send_pkt(10, 100, -1, 0, 100); drain();
    set_th(2'b11); send_pkt(11, 300, -1, 0, 300); drain();
    chk(rx_n - rx0 == 400, "R12 words under backpressure", rx_n - rx0, 400);
    chk(n_urun - u0c == 1, "R12 no underrun under backpressure", n_urun - u0c, 1);
    rdy_mode = 0;

    // oversize in store-and-forward
    set_th(2'b00); rx0 = rx_n; saw_full = 0;
    send_pkt(12, 600, -1, 0, 0); drain();
    chk(saw_full, "R10 writer stalled at 512 words", int'(saw_full), 1);
    chk(n_ovs == 1, "R11 oversize pulses", n_ovs, 1);
    chk(rx_n == rx0, "R11 nothing sent", rx_n - rx0, 0);
    send_pkt(13, 20, -1, 0, 20); drain();
    chk(rx_n - rx0 == 20, "R11 next packet intact", rx_n - rx0, 20);
    summary();
  end
endmodule